// File: doc/BRIEF.md
# Latched PWM Gate Logic

This block is the per-cycle decision logic between the oscillator, the comparators and the gate driver of a digital current-mode PWM controller. Each oscillator period ends with a dead-time pulse. When that pulse falls, a new conduction interval starts and the gate output is turned on. The gate is turned off by whichever comes first: the current-sense comparator, after a leading-edge blanking interval, or the duty-limit comparator. It is also turned off when the next dead time begins.

Once turned off, the gate stays off until the next period, so comparator chatter cannot produce a second pulse. A half-duty mode passes only every other oscillator period, which halves the switching frequency and keeps the duty below one half. Two further inputs hold the gate low. A duty-inhibit flag does so without latching. A fault input (undervoltage or disable) also clears the latch and the period-alternation state.

All inputs are synchronous to `clk`. The output is registered, so `gate_o` follows the inputs of a clock edge one cycle later.

Top module: `pwm_gate_logic`

## Requirements
- R1: While `rst` is high, and in the cycle after it is released, `gate_o` is 0. After reset, the first oscillator period that is allowed to run drives the gate.
- R2: A period starts on the clock edge where `osc_pulse_i` is sampled 0 after being sampled 1 on the previous edge. If that period is allowed and no duty-limit trip is sampled on that edge, `gate_o` is 1 after that edge.
- R3: Whenever `osc_pulse_i` is sampled 1, `gate_o` is 0 after that edge. The gate is therefore never on during dead time.
- R4: A sampled `dlim_trip_i` turns the latch off. If it is sampled on the same edge as a period start, the period does not drive the gate at all, because the turn-off wins.
- R5: `cs_trip_i` has no effect on the BLANK_CYC edges that follow a turn-on. From the next edge onwards, a sampled `cs_trip_i` turns the latch off.
- R6: After a turn-off, `gate_o` stays 0 until the next period start, whatever the comparators do. There is at most one output pulse per oscillator period.
- R7: With `half_mode_i` at 1, only alternate period starts are allowed. The alternation is cleared by reset and by fault, so the first period start after either of them is allowed.
- R8: While `dc_inhibit_i` is sampled 1, `gate_o` is 0 after that edge. The latch is not changed, so the gate resumes in the same period once the flag clears.
- R9: A sampled `fault_i` forces `gate_o` to 0 after that edge. It also clears the latch and the alternation state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| osc_pulse_i | input | 1 | Oscillator dead-time pulse; its falling edge starts a period |
| cs_trip_i | input | 1 | Current sense has reached the control level |
| dlim_trip_i | input | 1 | Ramp has crossed the duty-control level |
| half_mode_i | input | 1 | 1 selects half-frequency, sub-50% duty operation |
| dc_inhibit_i | input | 1 | Duty-control level is below its inhibit threshold |
| fault_i | input | 1 | Undervoltage or disable condition |
| gate_o | output | 1 | Registered gate-drive bit |

## Verification
The hardest case to produce is a current-sense trip that keeps toggling after the blanking interval. This case must still yield exactly one pulse in that period, with no rising edge of `gate_o` after the first turn-off. The stimulus runs complete oscillator periods and drives the comparator so that it starts chattering inside the period. It also drives a trip that falls entirely inside the blanking interval, and a duty-limit trip on the same edge as the period start, so that both edges of the blanking window and the set/reset priority are exercised. A fault is applied just before half-duty mode is enabled. This fixes the alternation phase, so the expected pattern of skipped periods is known from the ports alone.

// File: rtl/pwm_gate_pkg.sv
package pwm_gate_pkg;

  // width of a counter that must hold values 0..n
  function automatic int unsigned cnt_width(input int unsigned n);
    return (n < 2) ? 1 : $clog2(n + 1);
  endfunction

  // per-cycle latch command
  typedef struct packed {
    logic set;
    logic clr;
  } latch_cmd_t;

endpackage

// File: rtl/osc_edge_det.sv
module osc_edge_det (
  input  logic clk,
  input  logic rst,
  input  logic osc_i,
  output logic fall_o
);
  logic osc_q;

  always_ff @(posedge clk) begin
    if (rst) osc_q <= 1'b0;
    else     osc_q <= osc_i;
  end

  assign fall_o = osc_q & ~osc_i;

  AST_FALL_NOT_IN_DEAD: assert property (@(posedge clk) disable iff (rst)
    fall_o |-> (!osc_i && $past(osc_i))) else $error("fall flagged wrongly"); // R2
endmodule

// File: rtl/cycle_phase.sv
module cycle_phase (
  input  logic clk,
  input  logic rst,
  input  logic clr_i,
  input  logic fall_i,
  input  logic half_i,
  output logic allow_o
);
  logic phase_q;

  always_ff @(posedge clk) begin
    if (rst || clr_i) phase_q <= 1'b0;
    else if (fall_i)  phase_q <= ~phase_q;
  end

  assign allow_o = ~half_i | ~phase_q;

  AST_HALF_SKIP: assert property (@(posedge clk) disable iff (rst)
    (fall_i && half_i && !clr_i && allow_o) |=> (!half_i || !allow_o))
    else $error("half mode did not skip"); // R7
  AST_PHASE_CLEARED: assert property (@(posedge clk) disable iff (rst)
    clr_i |=> allow_o) else $error("phase not cleared"); // R9
endmodule

// File: rtl/blank_timer.sv
module blank_timer import pwm_gate_pkg::*; #(
  parameter int unsigned BLANK_CYC = 13
) (
  input  logic clk,
  input  logic rst,
  input  logic load_i,
  output logic busy_o
);
  localparam int unsigned CW = cnt_width(BLANK_CYC);
  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst)               cnt_q <= '0;
    else if (load_i)       cnt_q <= CW'(BLANK_CYC);
    else if (cnt_q != '0)  cnt_q <= cnt_q - 1'b1;
  end

  assign busy_o = (cnt_q != '0);

  AST_BLANK_LOADED: assert property (@(posedge clk) disable iff (rst)
    load_i |=> busy_o) else $error("blank window not started"); // R5
endmodule

// File: rtl/pwm_gate_logic.sv
module pwm_gate_logic import pwm_gate_pkg::*; #(
  parameter int unsigned BLANK_CYC = 13
) (
  input  logic clk,
  input  logic rst,
  input  logic osc_pulse_i,
  input  logic cs_trip_i,
  input  logic dlim_trip_i,
  input  logic half_mode_i,
  input  logic dc_inhibit_i,
  input  logic fault_i,
  output logic gate_o
);
  logic       fall_w, allow_w, busy_w, load_w;
  logic       lat_q, lat_d;
  latch_cmd_t cmd;

  osc_edge_det u_edge (
    .clk(clk), .rst(rst), .osc_i(osc_pulse_i), .fall_o(fall_w)
  );

  cycle_phase u_phase (
    .clk(clk), .rst(rst), .clr_i(fault_i), .fall_i(fall_w),
    .half_i(half_mode_i), .allow_o(allow_w)
  );

  blank_timer #(.BLANK_CYC(BLANK_CYC)) u_blank (
    .clk(clk), .rst(rst), .load_i(load_w), .busy_o(busy_w)
  );

  always_comb begin
    cmd.set = fall_w & allow_w & ~dlim_trip_i;
    cmd.clr = osc_pulse_i | dlim_trip_i | (cs_trip_i & ~busy_w);
    if (fault_i)          lat_d = 1'b0;
    else if (osc_pulse_i) lat_d = 1'b0;
    else if (fall_w)      lat_d = cmd.set;
    else if (cmd.clr)     lat_d = 1'b0;
    else                  lat_d = lat_q;
  end

  assign load_w = cmd.set & ~fault_i;

  always_ff @(posedge clk) begin
    if (rst) begin
      lat_q  <= 1'b0;
      gate_o <= 1'b0;
    end else begin
      lat_q  <= lat_d;
      gate_o <= lat_d & ~dc_inhibit_i;
    end
  end

  AST_DEAD_LOW: assert property (@(posedge clk) disable iff (rst)
    osc_pulse_i |=> !gate_o) else $error("gate on in dead time"); // R3
  AST_FAULT_LOW: assert property (@(posedge clk) disable iff (rst)
    fault_i |=> (!gate_o && !lat_q)) else $error("gate on in fault"); // R9
  AST_INHIBIT_LOW: assert property (@(posedge clk) disable iff (rst)
    dc_inhibit_i |=> !gate_o) else $error("gate on while inhibited"); // R8
  AST_ON_AT_FALL: assert property (@(posedge clk) disable iff (rst)
    $rose(lat_q) |-> $past(fall_w)) else $error("turn-on outside period start"); // R6
  AST_DLIM_OFF: assert property (@(posedge clk) disable iff (rst)
    (lat_q && dlim_trip_i) |=> !lat_q) else $error("duty limit ignored"); // R4
  AST_BLANK_HOLD: assert property (@(posedge clk) disable iff (rst)
    (lat_q && busy_w && !osc_pulse_i && !dlim_trip_i && !fault_i) |=> lat_q)
    else $error("current sense acted in blanking"); // R5
endmodule

// File: tb/pwm_gate_logic_bench.sv
`timescale 1ns/1ps
module pwm_gate_logic_bench;
  localparam int BLANK = 13;

  logic clk = 1'b0, rst = 1'b1;
  logic osc = 1'b0, cs = 1'b0, dlim = 1'b0, half = 1'b0, inh = 1'b0, flt = 1'b0;
  logic gate;

  always #4 clk = ~clk;

  pwm_gate_logic #(.BLANK_CYC(BLANK)) u_pwm_gate_logic (
    .clk(clk), .rst(rst), .osc_pulse_i(osc), .cs_trip_i(cs),
    .dlim_trip_i(dlim), .half_mode_i(half), .dc_inhibit_i(inh),
    .fault_i(flt), .gate_o(gate)
  );

  int    n_chk = 0, n_fail = 0, rises = 0;
  string cur_req = "R1";
  bit    done = 0;
  logic  last_gate = 1'b0;

  // behavioural reference model
  int m_lat = 0, m_prev = 0, m_phase = 0, m_age = 0;
  bit m_exp = 0;
  always @(posedge clk) begin
    bit fall_v;
    fall_v = (m_prev == 1) && !osc;
    if (rst || flt) begin m_lat = 0; m_phase = 0; m_age = 0; end
    else if (osc) m_lat = 0;
    else if (fall_v) begin
      m_lat = ((!half || m_phase == 0) && !dlim) ? 1 : 0;
      m_phase = 1 - m_phase;
      m_age = 0;
    end else if (m_lat == 1) begin
      m_age++;
      if (dlim || (cs && m_age > BLANK)) m_lat = 0;
    end
    m_prev = rst ? 0 : (osc ? 1 : 0);
    m_exp  = rst ? 0 : ((m_lat == 1) && !inh);
  end

  task automatic chk(input string req, input logic act, input logic exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0b expected=%0b at %0t", req, act, exp, $time);
    end
  endtask

  task automatic tick();
    @(negedge clk);
    chk(cur_req, gate, m_exp);
    if (gate && !last_gate) rises++;
    last_gate = gate;
  endtask

  task automatic run_cycle(input int dead, input int ramp, input int cs_at,
                           input int cs_len, input bit chat, input int dlim_at,
                           input int inh_at, input int inh_len,
                           input int flt_at, input int flt_len);
    rises = 0;
    for (int i = 0; i < dead; i++) begin
      tick(); osc = 1; cs = 0; dlim = 0; inh = 0; flt = 0;
    end
    for (int i = 0; i < ramp; i++) begin
      tick();
      osc  = 0;
      cs   = (cs_at >= 0 && i >= cs_at && (cs_len < 0 || i < cs_at + cs_len))
             ? (chat ? (((i - cs_at) % 2) == 0) : 1'b1) : 1'b0;
      dlim = (dlim_at >= 0 && i >= dlim_at);
      inh  = (inh_at >= 0 && i >= inh_at && i < inh_at + inh_len);
      flt  = (flt_at >= 0 && i >= flt_at && i < flt_at + flt_len);
    end
  endtask

  initial begin
    // R1: reset state
    repeat (4) begin tick(); osc = ~osc; end
    chk("R1 reset", gate, 1'b0);
    tick(); rst = 0; osc = 0;
    tick(); chk("R1 after release", gate, 1'b0);
    run_cycle(4, 30, -1, 0, 0, -1, -1, 0, -1, 0);
    chk("R1 first period drives", rises == 1, 1'b1);

    cur_req = "R2";
    run_cycle(3, 25, -1, 0, 0, -1, -1, 0, -1, 0);
    chk("R2 one pulse", rises == 1, 1'b1);
    cur_req = "R3";
    run_cycle(6, 20, -1, 0, 0, -1, -1, 0, -1, 0);
    run_cycle(2, 8, -1, 0, 0, -1, -1, 0, -1, 0);

    cur_req = "R4";
    run_cycle(4, 30, -1, 0, 0, 10, -1, 0, -1, 0);
    chk("R4 limited pulse", rises == 1, 1'b1);
    run_cycle(4, 30, -1, 0, 0, 0, -1, 0, -1, 0);
    chk("R4 trip at start wins", rises == 0, 1'b1);

    cur_req = "R5";
    run_cycle(4, 30, 2, 8, 0, -1, -1, 0, -1, 0);
    chk("R5 blanked trip ignored", rises == 1, 1'b1);
    run_cycle(4, 30, 2, -1, 0, -1, -1, 0, -1, 0);
    chk("R5 held trip acts after window", rises == 1, 1'b1);

    cur_req = "R6";
    run_cycle(4, 40, 16, -1, 1, -1, -1, 0, -1, 0);
    chk("R6 single pulse with chatter", rises == 1, 1'b1);
    run_cycle(4, 40, 1, -1, 1, 30, -1, 0, -1, 0);
    chk("R6 single pulse early chatter", rises == 1, 1'b1);

    cur_req = "R8";
    run_cycle(4, 30, -1, 0, 0, -1, 8, 4, -1, 0);
    chk("R8 resumes after inhibit", rises == 2, 1'b1);

    cur_req = "R9";
    run_cycle(4, 30, -1, 0, 0, -1, -1, 0, 10, 3);
    chk("R9 fault cuts pulse", rises == 1, 1'b1);
    half = 1;
    cur_req = "R7";
    run_cycle(4, 30, -1, 0, 0, -1, -1, 0, -1, 0);
    chk("R7 first period after fault", rises == 1, 1'b1);
    run_cycle(4, 30, -1, 0, 0, -1, -1, 0, -1, 0);
    chk("R7 skipped period", rises == 0, 1'b1);
    run_cycle(4, 30, -1, 0, 0, -1, -1, 0, -1, 0);
    chk("R7 third period", rises == 1, 1'b1);
    run_cycle(4, 30, 20, -1, 1, -1, -1, 0, -1, 0);
    chk("R7 skipped with chatter", rises == 0, 1'b1);
    half = 0;
    cur_req = "R2";
    run_cycle(4, 30, -1, 0, 0, -1, -1, 0, -1, 0);
    tick();

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      done = 1;
      n_chk++; n_fail++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
      $finish;
    end
  end
endmodule